// File: doc/BRIEF.md
# Loss-of-Frame Integrating Timer

This block turns a severely-errored-frame alarm into a loss-of-frame defect. Once per frame a strobe tells it whether that frame was errored. An out-of-frame timer adds up errored frames, so scattered errors are integrated over time instead of being thrown away. When the total reaches the integration limit, the defect is raised.

A separate in-frame timer counts consecutive clean frames. When that run reaches the same limit, the defect is cleared and the out-of-frame total goes back to zero. A loss-of-signal input counts as an errored frame on every strobe, so a dead line raises the defect after one full integration window.

Both timers count frame strobes, not clock cycles. The result is therefore the same at any line rate. At the default of 24 strobes of 125 µs each, the window is 3 ms.

Top module: `lof_integrator`

## Requirements
- R1: On a strobe with the alarm or loss-of-signal high, the out-of-frame total rises by one, saturating at TICKS (24). `lof_out` goes high at the clock edge that samples the strobe bringing the total to TICKS, and not on any earlier strobe.
- R2: Only strobes with the alarm or loss-of-signal high advance the out-of-frame total. A run of 23 such strobes leaves `lof_out` low.
- R3: A clean strobe (alarm and loss-of-signal both low) holds the out-of-frame total, as long as the clean run is shorter than TICKS strobes. A total split across such gaps still raises `lof_out` once it reaches TICKS.
- R4: A run of TICKS consecutive clean strobes resets the out-of-frame total to zero. After such a run, a further TICKS errored strobes are needed to raise `lof_out`.
- R5: While `lof_out` is high, it goes low at the edge that samples the TICKS-th consecutive clean strobe. Any errored strobe restarts that clean run from zero.
- R6: A single errored strobe followed by 7 clean strobes, repeated, raises `lof_out` on the TICKS-th errored strobe. A single errored strobe followed by TICKS clean strobes, repeated, never raises `lof_out`.
- R7: `los_in` high makes a strobe count as errored even when `sef_in` is low. With loss-of-signal held high, `lof_out` rises on the TICKS-th strobe, and loss-of-signal prevents `lof_out` from clearing.
- R8: In cycles where `frame_tick` is low, `sef_in` and `los_in` have no effect. Neither timer and not `lof_out` change.
- R9: With `rst` high at a clock edge, both timers are zeroed and `lof_out` is low at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | One-cycle strobe per received frame |
| sef_in | input | 1 | Severely-errored-frame alarm for the current frame |
| los_in | input | 1 | Loss of signal, treated as an errored frame |
| lof_out | output | 1 | Loss-of-frame defect |

## Verification
The timer is tried with one unbroken errored run, with errored runs split by clean gaps just under the limit, and with runs split by gaps of exactly the limit. These three patterns show whether the total is held through a gap or reset by it. A periodic one-in-eight error pattern is set against a one-in-twenty-five pattern to show that integration accumulates short-gap errors and discards widely spaced ones. Clearing is tried with an errored strobe placed inside the clean run, which shows whether the in-frame run restarts. Long stretches of alarm without strobes show that only strobes drive the timers.

// File: rtl/lof_pkg.sv
`timescale 1ns/1ps
package lof_pkg;

  // One frame's verdict, as seen by both timers.
  typedef struct packed {
    logic valid;    // a frame strobe is present this cycle
    logic errored;  // that frame is counted as out of frame
  } frame_evt_t;

  // Counter width able to hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Saturating step toward a limit (used by the timers).
  function automatic int unsigned sat_next(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

endpackage

// File: rtl/lof_evt_qual.sv
`timescale 1ns/1ps
module lof_evt_qual
  import lof_pkg::*;
(
  input  logic       frame_tick,
  input  logic       sef_in,
  input  logic       los_in,
  output frame_evt_t evt
);
  // Loss of signal forces every frame to count as errored.
  always_comb begin
    evt.valid   = frame_tick;
    evt.errored = sef_in | los_in;
  end
endmodule

// File: rtl/lof_timer.sv
`timescale 1ns/1ps
// Saturating frame counter. COUNT_ERRORED picks which frames advance it.
// HOLD_ON_OTHER picks what the opposite frame kind does: hold (1) or clear (0).
module lof_timer
  import lof_pkg::*;
#(
  parameter int unsigned TICKS         = 24,
  parameter bit          COUNT_ERRORED = 1'b1,
  parameter bit          HOLD_ON_OTHER = 1'b1,
  localparam int unsigned CW           = cnt_width(TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  frame_evt_t    evt,
  input  logic          zero_req,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  localparam logic [CW-1:0] TOP  = CW'(TICKS);

  logic advance, other;
  logic [CW-1:0] cnt_inc;

  assign advance = evt.valid && (evt.errored == COUNT_ERRORED);
  assign other   = evt.valid && (evt.errored != COUNT_ERRORED);
  assign cnt_inc = CW'(sat_next(int'(cnt), TICKS));
  assign hit     = advance && (cnt >= LAST);

  generate
    if (HOLD_ON_OTHER) begin : g_hold
      always_ff @(posedge clk) begin
        if (rst || zero_req) cnt <= '0;
        else if (advance)    cnt <= cnt_inc;
      end
    end else begin : g_clear
      always_ff @(posedge clk) begin
        if (rst || zero_req) cnt <= '0;
        else if (other)      cnt <= '0;
        else if (advance)    cnt <= (cnt >= TOP) ? TOP : cnt_inc;
      end
    end
  endgenerate
endmodule

// File: rtl/lof_integrator.sv
`timescale 1ns/1ps
module lof_integrator
  import lof_pkg::*;
#(
  parameter int unsigned TICKS = 24,
  localparam int unsigned CW   = cnt_width(TICKS)
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_tick,
  input  logic sef_in,
  input  logic los_in,
  output logic lof_out
);
  frame_evt_t    evt;
  logic [CW-1:0] oof_cnt, inf_cnt;
  logic          oof_hit, inf_hit;
  logic          lof_q;

  // Named events for the checker.
  logic evt_tick, evt_bad;
  assign evt_tick = evt.valid;
  assign evt_bad  = evt.errored;

  lof_evt_qual u_qual (
    .frame_tick (frame_tick),
    .sef_in     (sef_in),
    .los_in     (los_in),
    .evt        (evt)
  );

  // Out-of-frame total: advances on errored frames, holds on clean ones,
  // zeroed when the clean run completes.
  lof_timer #(.TICKS(TICKS), .COUNT_ERRORED(1'b1), .HOLD_ON_OTHER(1'b1)) u_oof (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .zero_req (inf_hit),
    .cnt      (oof_cnt),
    .hit      (oof_hit)
  );

  // Clean-run timer: advances on clean frames, restarts on errored ones.
  lof_timer #(.TICKS(TICKS), .COUNT_ERRORED(1'b0), .HOLD_ON_OTHER(1'b0)) u_inf (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .zero_req (1'b0),
    .cnt      (inf_cnt),
    .hit      (inf_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)          lof_q <= 1'b0;
    else if (oof_hit) lof_q <= 1'b1;
    else if (inf_hit) lof_q <= 1'b0;
  end

  assign lof_out = lof_q;
endmodule

// File: rtl/lof_integrator_chk.sv
`timescale 1ns/1ps
module lof_integrator_chk #(
  parameter int unsigned TICKS = 24,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          evt_tick,
  input logic          evt_bad,
  input logic          lof_out,
  input logic [CW-1:0] oof_cnt,
  input logic [CW-1:0] inf_cnt
);
  localparam logic [CW-1:0] TOP  = CW'(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  // R1
  oof_bound_chk: assert property (@(posedge clk) disable iff (rst) oof_cnt <= TOP);

  // R1
  lof_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lof_out) |-> $past(evt_tick && evt_bad));

  // R5
  lof_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lof_out) |-> $past(evt_tick && !evt_bad));

  // R5
  inf_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_tick && evt_bad) |=> (inf_cnt == '0));

  // R3
  oof_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_tick && !evt_bad && inf_cnt < LAST) |=> $stable(oof_cnt));

  // R8
  no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_tick |=> ($stable(lof_out) && $stable(oof_cnt) && $stable(inf_cnt)));
endmodule

bind lof_integrator lof_integrator_chk #(.TICKS(TICKS), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .evt_tick (evt_tick),
  .evt_bad  (evt_bad),
  .lof_out  (lof_out),
  .oof_cnt  (oof_cnt),
  .inf_cnt  (inf_cnt)
);

// File: tb/sim_lof_integrator.sv
`timescale 1ns/1ps
module sim_lof_integrator;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b0;
  logic sef_in = 1'b0;
  logic los_in = 1'b0;
  logic lof_out;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  lof_integrator #(.TICKS(N)) u0 (
    .clk(clk), .rst(rst), .frame_tick(frame_tick),
    .sef_in(sef_in), .los_in(los_in), .lof_out(lof_out)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (lof_out !== exp) begin
      fails++;
      $display("FAIL %s: lof_out=%b expected=%b at %0t", req, lof_out, exp, $time);
    end
  endtask

  // One frame strobe; result sampled at the following falling edge.
  task automatic frame(input logic s, input logic l);
    @(negedge clk);
    sef_in = s; los_in = l; frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0; sef_in = 1'b0; los_in = 1'b0;
  endtask

  task automatic frames(input int n, input logic s, input logic l);
    for (int i = 0; i < n; i++) frame(s, l);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; frame_tick = 1'b0; sef_in = 1'b0; los_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check(1'b0, "R9 reset state");
  endtask

  task automatic t_persist();
    do_reset();
    frames(N - 1, 1'b1, 1'b0);
    check(1'b0, "R2 23 errored frames");
    frame(1'b1, 1'b0);
    check(1'b1, "R1 24th errored frame");
    frames(5, 1'b1, 1'b0);
    check(1'b1, "R1 saturated total keeps LOF");
  endtask

  task automatic t_clear();
    do_reset();
    frames(N, 1'b1, 1'b0);
    frames(20, 1'b0, 1'b0);
    frame(1'b1, 1'b0);
    frames(N - 1, 1'b0, 1'b0);
    check(1'b1, "R5 clean run restarted by errored frame");
    frame(1'b0, 1'b0);
    check(1'b0, "R5 24th clean frame clears LOF");
    frames(N - 1, 1'b1, 1'b0);
    check(1'b0, "R4 total zeroed after clear");
    frame(1'b1, 1'b0);
    check(1'b1, "R4 full window needed again");
  endtask

  task automatic t_hold();
    do_reset();
    frames(12, 1'b1, 1'b0);
    frames(N - 1, 1'b0, 1'b0);
    frames(11, 1'b1, 1'b0);
    check(1'b0, "R3 held total 23");
    frame(1'b1, 1'b0);
    check(1'b1, "R3 held total reaches limit");
  endtask

  task automatic t_long_gap();
    do_reset();
    frames(12, 1'b1, 1'b0);
    frames(N, 1'b0, 1'b0);
    frames(N - 1, 1'b1, 1'b0);
    check(1'b0, "R4 long gap resets total");
    frame(1'b1, 1'b0);
    check(1'b1, "R4 fresh full window");
  endtask

  task automatic t_periodic();
    do_reset();
    for (int k = 0; k < N - 1; k++) begin
      frame(1'b1, 1'b0);
      frames(7, 1'b0, 1'b0);
    end
    check(1'b0, "R6 23 sparse errors");
    frame(1'b1, 1'b0);
    check(1'b1, "R6 24th sparse error raises LOF");
    do_reset();
    begin
      int raised = 0;
      for (int k = 0; k < 30; k++) begin
        frame(1'b1, 1'b0);
        if (lof_out) raised++;
        frames(N, 1'b0, 1'b0);
      end
      checks++;
      if (raised != 0) begin
        fails++;
        $display("FAIL R6 widely spaced errors: raised=%0d expected=0", raised);
      end
    end
  endtask

  task automatic t_los();
    do_reset();
    frames(N - 1, 1'b0, 1'b1);
    check(1'b0, "R7 23 frames of LOS");
    frame(1'b0, 1'b1);
    check(1'b1, "R7 LOS raises LOF");
    frames(N - 1, 1'b0, 1'b0);
    frame(1'b0, 1'b1);
    frames(N - 1, 1'b0, 1'b0);
    check(1'b1, "R7 LOS blocks clearing");
  endtask

  task automatic t_no_tick();
    do_reset();
    frames(N - 1, 1'b1, 1'b0);
    @(negedge clk);
    sef_in = 1'b1; los_in = 1'b1;
    repeat (100) @(negedge clk);
    sef_in = 1'b0; los_in = 1'b0;
    check(1'b0, "R8 alarm without strobe");
    frame(1'b1, 1'b0);
    check(1'b1, "R8 total untouched by unstrobed cycles");
    @(negedge clk);
    repeat (60) @(negedge clk);
    check(1'b1, "R8 clean unstrobed cycles keep LOF");
  endtask

  task automatic t_mid_reset();
    do_reset();
    frames(N, 1'b1, 1'b0);
    do_reset();
    check(1'b0, "R9 reset drops LOF");
    frames(N - 1, 1'b1, 1'b0);
    check(1'b0, "R9 reset zeroes total");
  endtask

  initial begin
    #(20ns * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_persist();
    t_clear();
    t_hold();
    t_long_gap();
    t_periodic();
    t_los();
    t_no_tick();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule